// File: doc/BRIEF.md
# Dual DAC Code and Configuration Controller

This block keeps the digital state behind a two-channel 10-bit DAC. Each channel has a volatile code that drives the converter, a retained (nonvolatile) shadow code and a power-down flag. An 8-bit retained configuration register sets the identifier that the bus slave matches against. It also sets the output state used while a channel is powered down, the code both channels take after reset, and a one-way lock.

A bus decoder in front of the block turns serial transactions into single-cycle command strobes. Each strobe carries an operation, a channel mask and a data word. The block applies the strobe on the next clock edge. A store copies volatile codes into the retained registers and then holds a busy flag for a programmable number of clock cycles, which models the write time of the nonvolatile array. The retained registers are plain flops that the reset does not touch, so their contents survive a reset as they would survive a power cycle.

Top module: `dual_dac_ctrl`

## Requirements
- R1: On the first clock edge after `rst_n` rises, both codes are loaded according to configuration bits 2:1. The encodings are 00 for 0x000, 01 for 0x3FF, 10 for 0x200, and 11 for each channel's retained code. A command strobe that arrives on that edge is ignored.
- R2: Operation code 0 (load) writes `cmd_data` into every channel selected by `cmd_sel`. Bit 0 of `cmd_sel` selects channel A and bit 1 selects channel B, so mask 11 writes the same value to both channels.
- R3: Operation code 1 (zero) sets the selected codes to 0x000. Operation code 2 (full) sets them to 0x3FF.
- R4: Operation code 3 (recall) copies each selected channel's retained code into its volatile code.
- R5: Operation code 4 (power-down) sets the selected channels' power-down flags. Each channel has a 2-bit `out_mode` field, with channel A in bits 1:0 and channel B in bits 3:2. The field reads 00 (drive) when the flag is clear. When the flag is set, it reads 01 (pulled low) if configuration bit 3 is 0 and 10 (high impedance) if that bit is 1. A later load, zero, full or recall to a channel clears its flag.
- R6: Operation code 5 (store) copies each selected volatile code into its retained register. `busy` then rises on the same edge and stays high for exactly STORE_CYCLES clock cycles.
- R7: A store strobe that arrives while `busy` is high is ignored entirely. Load, zero, full, recall and power-down strobes still take effect while `busy` is high.
- R8: A configuration write updates all 8 bits on the next edge. `cfg_rdata` then returns the register, and `dev_type_id` always shows bits 7:4. The register starts as 0x50, which is identifier 0101 with every other bit clear.
- R9: Once bit 0 (lock) of the configuration is 1, configuration writes are ignored and `cfg_rdata` reads 0x00. The lock persists across reset.
- R10: Retained codes and the configuration register keep their values across `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of volatile state |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 3 | Operation: 0 load, 1 zero, 2 full, 3 recall, 4 power-down, 5 store |
| cmd_sel | input | 2 | Channel mask, bit 0 channel A, bit 1 channel B |
| cmd_data | input | 10 | Code for the load operation |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value, 0x00 when locked |
| dev_type_id | output | 4 | Identifier for bus address matching |
| dac_code_a | output | 10 | Volatile code of channel A |
| dac_code_b | output | 10 | Volatile code of channel B |
| out_mode | output | 4 | Per-channel output state, A in 1:0, B in 3:2 |
| busy | output | 1 | Store cycle in progress |

## Verification
Two kinds of overlap get focused tests. The first is a command strobe that lands on the power-on recall edge: the bench raises `rst_n` with a load already presented and expects the configured policy value rather than the load data. The second is a store strobe that lands on the last busy cycle: the bench places it exactly there, then requires `busy` to fall on schedule and a later recall to return the earlier retained code. The same scenario also shows that a load issued in the middle of a store cycle reaches the output at once.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  parameter int unsigned DAC_W = 10;
  parameter int unsigned CFG_W = 8;
  parameter int unsigned ID_W  = 4;

  localparam int unsigned CFG_LOCK   = 0;
  localparam int unsigned CFG_POR_LO = 1;
  localparam int unsigned CFG_HIZ    = 3;
  localparam int unsigned CFG_ID_LO  = 4;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_ZERO   = 3'd1,
    OP_FULL   = 3'd2,
    OP_RECALL = 3'd3,
    OP_PWRDN  = 3'd4,
    OP_STORE  = 3'd5
  } dac_op_e;

  typedef enum logic [1:0] {
    MODE_DRIVE = 2'b00,
    MODE_LOW   = 2'b01,
    MODE_HIZ   = 2'b10
  } out_mode_e;

  // Code chosen after reset from the two policy bits.
  function automatic logic [DAC_W-1:0] por_value(input logic [1:0] pol,
                                                 input logic [DAC_W-1:0] nv);
    case (pol)
      2'b00:   por_value = '0;
      2'b01:   por_value = '1;
      2'b10:   por_value = {1'b1, {(DAC_W-1){1'b0}}};
      default: por_value = nv;
    endcase
  endfunction

  // True for the operations that rewrite a volatile code.
  function automatic logic is_update(input logic [2:0] op);
    is_update = (op == OP_LOAD) || (op == OP_ZERO) ||
                (op == OP_FULL) || (op == OP_RECALL);
  endfunction

  // New volatile code for an updating operation.
  function automatic logic [DAC_W-1:0] cmd_value(input logic [2:0] op,
                                                 input logic [DAC_W-1:0] data,
                                                 input logic [DAC_W-1:0] nv);
    case (op)
      OP_ZERO:   cmd_value = '0;
      OP_FULL:   cmd_value = '1;
      OP_RECALL: cmd_value = nv;
      default:   cmd_value = data;
    endcase
  endfunction

  function automatic logic [1:0] mode_of(input logic pd, input logic hiz);
    if (!pd)     mode_of = MODE_DRIVE;
    else if (hiz) mode_of = MODE_HIZ;
    else         mode_of = MODE_LOW;
  endfunction
endpackage

// File: rtl/dac_channel.sv
module dac_channel
  import dac_ctrl_pkg::*;
#(
  parameter logic [DAC_W-1:0] NV_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_apply,
  input  logic [1:0]       por_sel,
  input  logic             upd_en,
  input  logic [2:0]       upd_op,
  input  logic [DAC_W-1:0] upd_data,
  input  logic             pd_en,
  input  logic             store_en,
  output logic [DAC_W-1:0] vol_code,
  output logic [DAC_W-1:0] nv_code,
  output logic             pd_flag
);
  logic [DAC_W-1:0] vol_q;
  logic [DAC_W-1:0] nv_q = NV_INIT;  // retained: untouched by reset
  logic             pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q <= '0;
      pd_q  <= 1'b0;
    end else if (por_apply) begin
      vol_q <= por_value(por_sel, nv_q);
      pd_q  <= 1'b0;
    end else if (upd_en) begin
      vol_q <= cmd_value(upd_op, upd_data, nv_q);
      pd_q  <= 1'b0;
    end else if (pd_en) begin
      pd_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) nv_q <= vol_q;
  end

  assign vol_code = vol_q;
  assign nv_code  = nv_q;
  assign pd_flag  = pd_q;
endmodule

// File: rtl/dac_cfg_reg.sv
module dac_cfg_reg
  import dac_ctrl_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_INIT = 8'h50
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg,
  output logic             locked
);
  logic [CFG_W-1:0] cfg_q = CFG_INIT;  // retained: untouched by reset

  always_ff @(posedge clk) begin
    if (wr_en && !cfg_q[CFG_LOCK]) cfg_q <= wdata;
  end

  assign cfg    = cfg_q;
  assign locked = cfg_q[CFG_LOCK];
endmodule

// File: rtl/dac_store_timer.sv
module dac_store_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned      STORE_CYCLES = 250000,
  parameter logic [7:0]       CFG_INIT     = 8'h50,
  parameter logic [9:0]       NV_INIT_A    = 10'h000,
  parameter logic [9:0]       NV_INIT_B    = 10'h000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_sel,
  input  logic [9:0] cmd_data,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic [3:0] dev_type_id,
  output logic [9:0] dac_code_a,
  output logic [9:0] dac_code_b,
  output logic [3:0] out_mode,
  output logic       busy
);
  localparam int unsigned NCH = 2;

  // Named internal events, also observed by the bound checker.
  logic             por_pend;
  logic             por_apply;
  logic             cmd_live;
  logic             store_go;
  logic             cfg_locked;
  logic [CFG_W-1:0] cfg_q;
  logic [DAC_W-1:0] vol_code [NCH];
  logic [DAC_W-1:0] nv_code  [NCH];
  logic [NCH-1:0]   pd_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_pend <= 1'b1;
    else        por_pend <= 1'b0;
  end

  assign por_apply = por_pend;
  assign cmd_live  = cmd_valid && !por_apply;
  assign store_go  = cmd_live && (cmd_op == OP_STORE) && !busy;

  dac_cfg_reg #(.CFG_INIT(CFG_INIT)) u_cfg (
    .clk    (clk),
    .wr_en  (cfg_wr),
    .wdata  (cfg_wdata),
    .cfg    (cfg_q),
    .locked (cfg_locked)
  );

  dac_store_timer #(.CYCLES(STORE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (store_go),
    .busy  (busy)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_channel #(.NV_INIT((i == 0) ? NV_INIT_A : NV_INIT_B)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_apply (por_apply),
      .por_sel   (cfg_q[CFG_POR_LO +: 2]),
      .upd_en    (cmd_live && is_update(cmd_op) && cmd_sel[i]),
      .upd_op    (cmd_op),
      .upd_data  (cmd_data),
      .pd_en     (cmd_live && (cmd_op == OP_PWRDN) && cmd_sel[i]),
      .store_en  (store_go && cmd_sel[i]),
      .vol_code  (vol_code[i]),
      .nv_code   (nv_code[i]),
      .pd_flag   (pd_flag[i])
    );
    assign out_mode[2*i +: 2] = mode_of(pd_flag[i], cfg_q[CFG_HIZ]);
  end

  assign dac_code_a  = vol_code[0];
  assign dac_code_b  = vol_code[1];
  assign cfg_rdata   = cfg_locked ? '0 : cfg_q;
  assign dev_type_id = cfg_q[CFG_ID_LO +: ID_W];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dac_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             por_apply,
  input logic             cmd_live,
  input logic [2:0]       cmd_op,
  input logic [1:0]       cmd_sel,
  input logic             store_go,
  input logic             busy,
  input logic             cfg_locked,
  input logic [CFG_W-1:0] cfg_q,
  input logic [7:0]       cfg_rdata,
  input logic [DAC_W-1:0] dac_code_a,
  input logic [DAC_W-1:0] nv_a,
  input logic [3:0]       out_mode
);
  assert_por_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_apply |=> dac_code_a == por_value($past(cfg_q[2:1]), $past(nv_a)));

  assert_zero_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && cmd_op == OP_ZERO && cmd_sel[0]) |=> dac_code_a == '0);

  assert_pd_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && cmd_op == OP_PWRDN && cmd_sel[0]) |=> out_mode[1:0] != MODE_DRIVE);

  assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode[1:0] != 2'b11 && out_mode[3:2] != 2'b11);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> busy);

  assert_busy_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(store_go));

  assert_no_store_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !store_go);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> cfg_locked && $stable(cfg_q));

  assert_lock_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |-> cfg_rdata == 8'h00);
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_apply  (por_apply),
  .cmd_live   (cmd_live),
  .cmd_op     (cmd_op),
  .cmd_sel    (cmd_sel),
  .store_go   (store_go),
  .busy       (busy),
  .cfg_locked (cfg_locked),
  .cfg_q      (cfg_q),
  .cfg_rdata  (cfg_rdata),
  .dac_code_a (dac_code_a),
  .nv_a       (nv_code[0]),
  .out_mode   (out_mode)
);

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb;
  import dac_ctrl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int STORE_N    = 40;
  localparam logic [9:0] NVA0 = 10'h111;
  localparam logic [9:0] NVB0 = 10'h222;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_sel = 2'b00;
  logic [9:0] cmd_data = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] dev_type_id;
  logic [9:0] dac_code_a, dac_code_b;
  logic [3:0] out_mode;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_ctrl #(
    .STORE_CYCLES(STORE_N), .CFG_INIT(8'h50),
    .NV_INIT_A(NVA0), .NV_INIT_B(NVB0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_type_id(dev_type_id),
    .dac_code_a(dac_code_a), .dac_code_b(dac_code_b), .out_mode(out_mode),
    .busy(busy)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] sel,
                       input logic [9:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Reset pulse; a load strobe sits on the first edge after release.
  task automatic reset_with_cmd();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_LOAD; cmd_sel = 2'b11; cmd_data = 10'h155;
    rst_n = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_defaults();
    check("R1", "code A after reset", dac_code_a, 10'h000);
    check("R1", "code B after reset", dac_code_b, 10'h000);
    check("R8", "initial cfg read", cfg_rdata, 8'h50);
    check("R8", "initial id", dev_type_id, 4'h5);
    check("R5", "initial modes", out_mode, 4'b0000);
    check("R6", "idle busy", busy, 1'b0);
  endtask

  task automatic t_por_policies();
    logic [9:0] exp_a, exp_b;
    for (int p = 0; p < 4; p++) begin
      cfg_write({4'h5, 1'b0, 2'(p), 1'b0});
      check("R8", "cfg write read", cfg_rdata, {4'h5, 1'b0, 2'(p), 1'b0});
      reset_with_cmd();
      case (p)
        0: begin exp_a = 10'h000; exp_b = 10'h000; end
        1: begin exp_a = 10'h3FF; exp_b = 10'h3FF; end
        2: begin exp_a = 10'h200; exp_b = 10'h200; end
        default: begin exp_a = NVA0; exp_b = NVB0; end
      endcase
      check("R1", $sformatf("policy %0d code A", p), dac_code_a, exp_a);
      check("R1", $sformatf("policy %0d code B", p), dac_code_b, exp_b);
      check("R10", "cfg kept over reset", cfg_rdata, {4'h5, 1'b0, 2'(p), 1'b0});
    end
    cfg_write(8'h50);
  endtask

  task automatic t_load_scale();
    issue(OP_LOAD, 2'b01, 10'h155);
    check("R2", "load A", dac_code_a, 10'h155);
    check("R2", "load A leaves B", dac_code_b, NVB0);
    issue(OP_LOAD, 2'b10, 10'h2AA);
    check("R2", "load B", dac_code_b, 10'h2AA);
    check("R2", "load B leaves A", dac_code_a, 10'h155);
    issue(OP_LOAD, 2'b11, 10'h3C3);
    check("R2", "write both A", dac_code_a, 10'h3C3);
    check("R2", "write both B", dac_code_b, 10'h3C3);
    issue(OP_FULL, 2'b01, 10'h000);
    check("R3", "full A", dac_code_a, 10'h3FF);
    issue(OP_ZERO, 2'b10, 10'h3FF);
    check("R3", "zero B", dac_code_b, 10'h000);
    check("R3", "zero B leaves A", dac_code_a, 10'h3FF);
    issue(OP_ZERO, 2'b11, 10'h155);
    check("R3", "zero both A", dac_code_a, 10'h000);
    check("R3", "zero both B", dac_code_b, 10'h000);
  endtask

  task automatic t_store_recall();
    int cnt;
    issue(OP_LOAD, 2'b01, 10'h123);
    issue(OP_LOAD, 2'b10, 10'h0F0);
    issue(OP_STORE, 2'b11, 10'h000);
    check("R6", "busy after store", busy, 1'b1);
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check("R6", "busy length", cnt, STORE_N);
    issue(OP_LOAD, 2'b11, 10'h000);
    issue(OP_RECALL, 2'b11, 10'h3FF);
    check("R4", "recall A", dac_code_a, 10'h123);
    check("R4", "recall B", dac_code_b, 10'h0F0);
  endtask

  task automatic t_store_busy();
    issue(OP_LOAD, 2'b01, 10'h2F0);
    issue(OP_STORE, 2'b01, 10'h000);
    issue(OP_LOAD, 2'b01, 10'h001);
    check("R7", "load while busy", dac_code_a, 10'h001);
    check("R7", "still busy", busy, 1'b1);
    repeat (STORE_N - 3) @(negedge clk);
    check("R6", "busy in last cycle", busy, 1'b1);
    cmd_valid = 1'b1; cmd_op = OP_STORE; cmd_sel = 2'b01; cmd_data = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R7", "store in last busy cycle ignored", busy, 1'b0);
    issue(OP_RECALL, 2'b01, 10'h000);
    check("R7", "retained A unchanged", dac_code_a, 10'h2F0);
    issue(OP_STORE, 2'b01, 10'h000);
    check("R6", "store accepted when idle", busy, 1'b1);
    while (busy) @(negedge clk);
  endtask

  task automatic t_powerdown();
    issue(OP_PWRDN, 2'b01, 10'h000);
    check("R5", "pd A low", out_mode, 4'b0001);
    cfg_write(8'h58);
    check("R5", "pd A hiz", out_mode, 4'b0010);
    issue(OP_LOAD, 2'b01, 10'h100);
    check("R5", "load clears pd", out_mode, 4'b0000);
    check("R2", "load after pd", dac_code_a, 10'h100);
    issue(OP_PWRDN, 2'b11, 10'h000);
    check("R5", "pd both hiz", out_mode, 4'b1010);
    issue(OP_RECALL, 2'b10, 10'h000);
    check("R5", "recall clears B only", out_mode, 4'b0010);
    issue(OP_FULL, 2'b01, 10'h000);
    check("R5", "full clears A", out_mode, 4'b0000);
    cfg_write(8'h50);
  endtask

  task automatic t_retain();
    cfg_write(8'h56);
    reset_with_cmd();
    check("R10", "retained A over reset", dac_code_a, 10'h2F0);
    check("R10", "retained B over reset", dac_code_b, 10'h0F0);
  endtask

  task automatic t_lock();
    cfg_write(8'hA5);
    check("R9", "locked read", cfg_rdata, 8'h00);
    check("R9", "id after lock", dev_type_id, 4'hA);
    cfg_write(8'h50);
    check("R9", "write ignored id", dev_type_id, 4'hA);
    check("R9", "still locked read", cfg_rdata, 8'h00);
    reset_with_cmd();
    check("R9", "locked policy after reset A", dac_code_a, 10'h200);
    check("R9", "locked policy after reset B", dac_code_b, 10'h200);
    check("R9", "lock persists", cfg_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_defaults();
    t_por_policies();
    t_load_scale();
    t_store_recall();
    t_store_busy();
    t_powerdown();
    t_retain();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (100000) @(posedge clk);
    join_any
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule